// File: doc/BRIEF.md
# Flash Completion Poller

This block is the host-side engine that waits for a flash program or erase operation to finish. A caller starts it with the operation kind, the address to poll, the data that was written, and a limit on polling reads. The engine then reads the flash repeatedly through a request/response read port. After each read it compares status bit 7 of the returned word with the value that signals completion.

A single bit 7 match is not trusted. The status may switch over to array contents in the middle of a read, so the engine issues a confirming re-read. Bit 7 can also settle before the other bits, so the engine takes the full word from one further read. It then raises `done` for one cycle with a pass flag, a timeout flag and the final word. While the flash busy pin is low, the engine holds back polling reads.

Both the start port and the read-request port are valid/ready streams. A transfer takes place on a rising clock edge where valid and ready are both high. Once the engine raises `rd_req_valid`, it keeps the request and its address unchanged until `rd_req_ready` accepts it. `start_ready` stays low from the accepted start until `done`, so the caller's start is held off while an operation is in flight. The response side uses `rd_rsp_ready`, which is high only while a read is outstanding. The flash side must return exactly one response for each accepted request.

Top module: `dpoll_engine`

## Requirements
- R1: `start_ready` is high only while the engine is idle. A start offered while an operation is in flight is ignored and does not change the result.
- R2: For a program (`start_op`=0), a read counts as a match when its bit 7 equals bit 7 of `start_data`. Other bits of the word do not matter for the match.
- R3: For an erase (`start_op`=1), a read counts as a match when its bit 7 is 1, whatever `start_data` holds.
- R4: The first match is followed by a confirming re-read. If the re-read does not match, polling resumes.
- R5: After a matching confirm read, one final read is made. `final_data` is the word that final read returns, so a clean completion uses at least three reads.
- R6: A completed program reports `pass`=1 only if the final word equals `start_data`. A completed erase always reports `pass`=1.
- R7: Polling reads are counted against `max_polls`. A non-matching read made when the count has reached the limit ends the operation with `timeout`=1 and `pass`=0. Confirm and final reads are not counted.
- R8: Every read request carries the address latched at start.
- R9: With the default `USE_BUSY_SKIP`=1, no new polling read is offered while `busy_n` is low.
- R10: `done` is high for exactly one cycle per operation. `start_ready` returns high in the next cycle.
- R11: An offered read request keeps `rd_req_valid` and `rd_req_addr` steady until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Engine idle, start accepted |
| start_op | input | 1 | 0 program, 1 erase |
| start_addr | input | AW | Address to poll |
| start_data | input | DW | Data written by the program |
| max_polls | input | CW | Polling read limit |
| busy_n | input | 1 | Flash busy pin, low while busy |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine waiting for read data |
| rd_rsp_data | input | DW | Read data |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded |
| timeout | output | 1 | Poll limit reached |
| final_data | output | DW | Word from the last read |

## Verification
Program runs use scripted read words whose bit 7 first shows the complement and then the written value, with junk in the other bits. This tells the bit 7 decision apart from a whole-word compare. One program writes a word with bit 7 clear, which separates the program rule from the erase rule. An erase run passes `start_data` with bit 7 clear, so it only completes under the erase rule.

A run whose confirm read falls back to the complement separates a design that trusts the first match from one that re-reads. A run with a mismatching final word exposes a missing data compare. Further runs cover an exhausted poll budget with back-pressure on the request port, a busy pin held low, and a start offered mid-operation. They show, respectively, the timeout, the request hold, the busy skip and the start lock-out.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
  typedef enum logic [1:0] {PH_POLL, PH_CONFIRM, PH_FINAL} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} state_e;
endpackage

// File: rtl/dpoll_judge.sv
// Decides whether one read word shows completion, and whether it equals the expected word.
module dpoll_judge #(
  parameter int DW       = 32,
  parameter int FLAG_BIT = 7
) (
  input  logic          is_erase,
  input  logic [DW-1:0] expect_word,
  input  logic [DW-1:0] read_word,
  output logic          hit,
  output logic          word_eq
);
  logic want;
  // erase completes on a one; program completes on the true written bit
  assign want    = is_erase ? 1'b1 : expect_word[FLAG_BIT];
  assign hit     = (read_word[FLAG_BIT] == want);
  assign word_eq = (read_word == expect_word);
endmodule

// File: rtl/dpoll_budget.sv
// Counts polling reads and flags when the limit is reached.
module dpoll_budget #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          exhausted
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (clear)                   cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign exhausted = (cnt_q >= limit);
endmodule

// File: rtl/dpoll_seq.sv
// Sequencer: poll, confirm, final read, then report.
module dpoll_seq
  import dpoll_pkg::*;
#(
  parameter int  DW            = 32,
  parameter bit  USE_BUSY_SKIP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  output logic          accept,
  input  logic          is_erase,
  input  logic          busy_n,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data,
  input  logic          hit,
  input  logic          word_eq,
  input  logic          exhausted,
  output logic          poll_issue,
  output logic          done,
  output logic          pass,
  output logic          timeout,
  output logic [DW-1:0] final_data
);
  state_e        st_q;
  phase_e        ph_q;
  logic          held_q;
  logic          gate;
  logic          req_fire;
  logic          rsp_fire;

  generate
    if (USE_BUSY_SKIP) begin : g_busy_skip
      assign gate = (ph_q == PH_POLL) && !busy_n;
    end else begin : g_no_skip
      assign gate = 1'b0;
    end
  endgenerate

  assign start_ready  = (st_q == ST_IDLE);
  assign accept       = start_valid && start_ready;
  // once offered, a request stays up regardless of busy
  assign rd_req_valid = (st_q == ST_ISSUE) && (!gate || held_q);
  assign req_fire     = rd_req_valid && rd_req_ready;
  assign rd_rsp_ready = (st_q == ST_WAIT);
  assign rsp_fire     = rd_rsp_valid && rd_rsp_ready;
  assign poll_issue   = req_fire && (ph_q == PH_POLL);
  assign done         = (st_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_POLL;
      held_q     <= 1'b0;
      pass       <= 1'b0;
      timeout    <= 1'b0;
      final_data <= '0;
    end else begin
      held_q <= rd_req_valid && !rd_req_ready;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_ISSUE;
          ph_q    <= PH_POLL;
          pass    <= 1'b0;
          timeout <= 1'b0;
        end
        ST_ISSUE: if (req_fire) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_fire) begin
          st_q <= ST_ISSUE;
          unique case (ph_q)
            PH_POLL: begin
              if (hit) ph_q <= PH_CONFIRM;
              else if (exhausted) begin
                st_q       <= ST_DONE;
                timeout    <= 1'b1;
                pass       <= 1'b0;
                final_data <= rd_rsp_data;
              end
            end
            PH_CONFIRM: begin
              if (hit) ph_q <= PH_FINAL;
              else if (exhausted) begin
                st_q       <= ST_DONE;
                timeout    <= 1'b1;
                pass       <= 1'b0;
                final_data <= rd_rsp_data;
              end else ph_q <= PH_POLL;
            end
            default: begin
              st_q       <= ST_DONE;
              final_data <= rd_rsp_data;
              pass       <= is_erase | word_eq;
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_start_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);
  p_confirm_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && ph_q == PH_POLL && hit) |=> (ph_q == PH_CONFIRM));
  p_erase_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !timeout && is_erase) |-> pass);
  p_timeout_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> (!pass && exhausted));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_BUSY_SKIP && !busy_n && !rd_req_valid && ph_q == PH_POLL)
      |=> (busy_n || !rd_req_valid || ph_q != PH_POLL));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && start_ready));
endmodule

// File: rtl/dpoll_engine.sv
module dpoll_engine
  import dpoll_pkg::*;
#(
  parameter int DW            = 32,
  parameter int AW            = 20,
  parameter int CW            = 16,
  parameter int FLAG_BIT      = 7,
  parameter bit USE_BUSY_SKIP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic          start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_data,
  input  logic [CW-1:0] max_polls,
  input  logic          busy_n,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          done,
  output logic          pass,
  output logic          timeout,
  output logic [DW-1:0] final_data
);
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [CW-1:0] lim_q;
  logic          accept, hit, word_eq, exhausted, poll_issue, is_erase;

  // operation context, captured once per accepted start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      addr_q <= '0;
      exp_q  <= '0;
      lim_q  <= '0;
    end else if (accept) begin
      op_q   <= op_e'(start_op);
      addr_q <= start_addr;
      exp_q  <= start_data;
      lim_q  <= max_polls;
    end
  end

  assign is_erase    = (op_q == OP_ERASE);
  assign rd_req_addr = addr_q;

  dpoll_judge #(.DW(DW), .FLAG_BIT(FLAG_BIT)) judge_i (
    .is_erase(is_erase), .expect_word(exp_q), .read_word(rd_rsp_data),
    .hit(hit), .word_eq(word_eq));

  dpoll_budget #(.CW(CW)) budget_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .inc(poll_issue),
    .limit(lim_q), .exhausted(exhausted));

  dpoll_seq #(.DW(DW), .USE_BUSY_SKIP(USE_BUSY_SKIP)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .accept(accept), .is_erase(is_erase), .busy_n(busy_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .hit(hit), .word_eq(word_eq), .exhausted(exhausted), .poll_issue(poll_issue),
    .done(done), .pass(pass), .timeout(timeout), .final_data(final_data));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
endmodule

// File: tb/dpoll_engine_tb_top.sv
module dpoll_engine_tb_top;
  localparam int DW = 32;
  localparam int AW = 20;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start_valid, start_ready, start_op, busy_n;
  logic [AW-1:0] start_addr, rd_req_addr;
  logic [DW-1:0] start_data, rd_rsp_data, final_data;
  logic [CW-1:0] max_polls;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic done, pass, timeout;

  dpoll_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_op(start_op), .start_addr(start_addr), .start_data(start_data),
    .max_polls(max_polls), .busy_n(busy_n), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data), .done(done), .pass(pass),
    .timeout(timeout), .final_data(final_data));

  typedef struct {
    bit          pass;
    bit          tmo;
    logic [31:0] data;
    bit          chk_data;
    int          reads;
    string       tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [31:0]   rsp_q[$];
  int            checks = 0;
  int            failures = 0;
  int            reads_seen = 0;
  logic [AW-1:0] cur_addr = '0;
  bit            stall = 0;
  bit            req_seen = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // flash model: one response per accepted request, one cycle later
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = '0;
      rd_req_ready = 1'b1;
      req_seen     = 0;
    end else begin
      rd_rsp_valid = 1'b0;
      if (req_seen) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = (rsp_q.size() != 0) ? rsp_q.pop_front() : 32'h0;
        req_seen     = 0;
      end
      rd_req_ready = stall ? ~rd_req_ready : 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        req_seen = 1;
        reads_seen++;
        chk(rd_req_addr == cur_addr, "R8", "read address", rd_req_addr, cur_addr);
      end
    end
  end

  // monitor: scoreboard compare on each completion pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(pass == e.pass, e.tag, "pass", pass, e.pass);
        chk(timeout == e.tmo, e.tag, "timeout", timeout, e.tmo);
        chk(reads_seen == e.reads, e.tag, "read count", reads_seen, e.reads);
        if (e.chk_data) chk(final_data == e.data, e.tag, "final_data", final_data, e.data);
      end
    end
  end

  task automatic run_op(input bit op, input logic [AW-1:0] a, input logic [31:0] d,
                        input int maxp, input logic [31:0] words[$],
                        input bit epass, input bit etmo, input logic [31:0] edata,
                        input bit cdata, input int ereads, input string tag,
                        input bit intrude);
    exp_t e;
    foreach (words[i]) rsp_q.push_back(words[i]);
    e.pass = epass; e.tmo = etmo; e.data = edata; e.chk_data = cdata;
    e.reads = ereads; e.tag = tag;
    exp_q.push_back(e);
    reads_seen = 0;
    cur_addr   = a;
    @(negedge clk);
    start_valid = 1'b1; start_op = op; start_addr = a; start_data = d;
    max_polls = maxp[CW-1:0];
    @(negedge clk);
    start_valid = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk(start_ready == 1'b0, "R1", "start_ready while running", start_ready, 0);
      start_valid = 1'b1; start_op = ~op; start_addr = ~a; start_data = ~d;
      @(negedge clk);
      start_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(start_ready == 1'b1, "R10", "start_ready after done", start_ready, 1);
    rsp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_valid = 1'b0; start_op = 1'b0; start_addr = '0;
    start_data = '0; max_polls = '0; busy_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_ready == 1'b1, "R1", "reset start_ready", start_ready, 1);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    chk(rd_req_valid == 1'b0, "R11", "reset rd_req_valid", rd_req_valid, 0);

    // R2/R5: program, bit 7 set, junk in low bits on the matching read
    run_op(1'b0, 20'h12345, 32'h0000_0080, 50,
           '{32'h0, 32'h0, 32'h0000_0085, 32'h0000_0080, 32'h0000_0080},
           1'b1, 1'b0, 32'h0000_0080, 1'b1, 5, "R2", 1'b0);

    // R4: confirm read falls back, polling resumes
    run_op(1'b0, 20'h00ABC, 32'h0000_00F0, 50,
           '{32'h0, 32'h80, 32'h0, 32'hF0, 32'hF0, 32'hF0},
           1'b1, 1'b0, 32'h0000_00F0, 1'b1, 6, "R4", 1'b0);

    // R6: bit 7 matches but final word differs -> fail
    run_op(1'b0, 20'h00100, 32'h0000_007F, 50,
           '{32'h80, 32'h12, 32'h13, 32'h13},
           1'b0, 1'b0, 32'h0000_0013, 1'b1, 4, "R6", 1'b0);

    // R3: erase, start_data bit 7 clear must not matter
    run_op(1'b1, 20'h40000, 32'h0, 50,
           '{32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
           1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 5, "R3", 1'b0);

    // R7/R11: poll limit of 3 with a stalling request port
    stall = 1;
    run_op(1'b0, 20'h00777, 32'h0000_0080, 3, '{32'h0, 32'h0, 32'h0, 32'h0},
           1'b0, 1'b1, 32'h0, 1'b0, 3, "R7", 1'b0);
    run_op(1'b1, 20'h00778, 32'h0, 60, '{32'h0, 32'h80, 32'h80, 32'h80},
           1'b1, 1'b0, 32'h80, 1'b1, 4, "R11", 1'b0);
    stall = 0;

    // R9: no polling read while busy is low
    begin
      int viol = 0;
      busy_n = 1'b0;
      fork
        run_op(1'b1, 20'h0F0F0, 32'h0, 50, '{32'hFF, 32'hFF, 32'hFF},
               1'b1, 1'b0, 32'hFF, 1'b1, 3, "R9", 1'b0);
        begin
          repeat (20) begin
            @(negedge clk);
            if (rd_req_valid) viol++;
          end
          busy_n = 1'b1;
        end
      join
      chk(viol == 0, "R9", "reads offered while busy", viol, 0);
    end

    // R1: a start offered mid-operation is ignored
    run_op(1'b0, 20'h05555, 32'h0000_0055, 50,
           '{32'h80, 32'h80, 32'h80, 32'h55, 32'h55, 32'h55},
           1'b1, 1'b0, 32'h0000_0055, 1'b1, 6, "R1", 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule